// File: doc/BRIEF.md
# Multi-channel supply/digital gain splitter

This block divides a set of per-channel volume requests between two gain stages. One stage is a shared power-supply gain, which scales the output stage supply rail for all channels. The other is a digital gain applied to each channel on its own. For each channel the two gains add up to the request. The shared supply gain follows the loudest included channel. It is held inside a selectable control range that ends at 0 dB, so the supply never boosts. Each channel's digital gain is then its request minus that shared supply gain.

A controller presents the channel requests and configuration, then pulses `start`. The block takes a snapshot of all inputs. It spends one clock per channel searching for the maximum, one clock clamping it into the supply range, and one clock per channel forming the digital gains. It then pulses `done` and holds every result until the next accepted start. The supply path can be switched off, so that all volume goes through digital gain. The last channel (the subwoofer) can be kept out of the supply decision, which is needed when it drives a line output.

Top module: `gain_splitter`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `sup_gain` and every digital gain field are 0.
- R2: A `start` sampled high while idle captures all inputs and raises `busy`. A `start` sampled while `busy` is high is ignored: the running computation keeps its captured inputs, and no extra run follows.
- R3: `done` is high for exactly one cycle, at the sampling point 2·NUM_CH+2 edges after the edge that accepted `start` (18 for eight channels), and `busy` is low from then on.
- R4: All values are signed two's complement with 1 LSB = 0.5 dB. The search covers every included channel. If the largest included request is above 0, `sup_gain` is 0.
- R5: If the largest included request lies between the range floor and 0 inclusive, `sup_gain` equals that request.
- R6: If the largest included request is below the range floor, `sup_gain` equals the floor. `range_sel` 0 gives a floor of -24 (12 dB), 1 gives -36 (18 dB) and 2 gives -48 (24 dB). The reserved code 3 behaves as 0.
- R7: The digital gain of each included channel, held in bits [c·VOL_W +: VOL_W] of `dig_gain`, equals its request minus `sup_gain`, saturated to the signed VOL_W range.
- R8: When `sup_en` is low at start, `sup_gain` is 0 and each digital gain equals its own request.
- R9: When `sub_excl` is high at start, channel NUM_CH-1 takes no part in the maximum search, and its digital gain equals its own request.
- R10: `sup_gain` and `dig_gain` stay constant from `done` until an accepted start changes them. A `start` in the same cycle as `done` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation (accepted only when idle) |
| sup_en | input | 1 | Enable the supply gain path |
| sub_excl | input | 1 | Exclude the last channel from supply gain |
| range_sel | input | 2 | Supply control range code |
| vol_in | input | NUM_CH·VOL_W | Requested volumes, channel c in bits [c·VOL_W +: VOL_W] |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| sup_gain | output | VOL_W | Shared supply gain, half-dB units |
| dig_gain | output | NUM_CH·VOL_W | Per-channel digital gains, half-dB units |

## Verification
Two events can land in the same cycle: a run finishing (`done`) and a new request arriving (`start`). The bench sees `done` and raises `start` with new volumes in that very cycle. The finished results must be readable in that cycle, and the new run must complete at the exact latency with the new values. A second coincidence, `start` arriving while a run is still going, must be ignored. The bench checks this through the unchanged results and through the absence of any extra `done`. Beyond these, a deterministic sweep of several hundred volume sets covers every range code, both enables and the loudest-is-subwoofer case, each checked against an arithmetic model.

// File: rtl/gs_pkg.sv
package gs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_CLAMP = 2'd2,
    ST_SUB   = 2'd3
  } phase_t;

  // control range span in whole dB, selected by the 2-bit range code
  function automatic int range_db(input logic [1:0] code);
    case (code)
      2'd1:    range_db = 18;
      2'd2:    range_db = 24;
      default: range_db = 12;
    endcase
  endfunction
endpackage

// File: rtl/gs_ctrl.sv
module gs_ctrl #(
  parameter int NUM_CH = 8,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             load,
  output logic             scan_en,
  output logic             clamp_en,
  output logic             wr_en,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             done
);
  import gs_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CH - 1);

  phase_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_SCAN;
            idx   <= '0;
          end
        end
        ST_SCAN: begin
          if (idx == LAST) begin
            idx   <= '0;
            state <= ST_CLAMP;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_CLAMP: state <= ST_SUB;
        default: begin
          if (idx == LAST) begin
            idx   <= '0;
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      endcase
    end
  end

  assign load     = (state == ST_IDLE) && start;
  assign scan_en  = (state == ST_SCAN);
  assign clamp_en = (state == ST_CLAMP);
  assign wr_en    = (state == ST_SUB);
  assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/gs_max_scan.sv
module gs_max_scan #(
  parameter int VOL_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    en,
  input  logic                    valid,
  input  logic signed [VOL_W-1:0] din,
  output logic signed [VOL_W-1:0] max_q,
  output logic                    seen
);
  localparam logic signed [VOL_W-1:0] MOST_NEG = {1'b1, {(VOL_W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      max_q <= MOST_NEG;
      seen  <= 1'b0;
    end else if (en && valid) begin
      seen <= 1'b1;
      if (!seen || din > max_q) max_q <= din;
    end
  end
endmodule

// File: rtl/gs_sub_sat.sv
module gs_sub_sat #(
  parameter int VOL_W = 8
) (
  input  logic signed [VOL_W-1:0] a,
  input  logic signed [VOL_W-1:0] b,
  output logic signed [VOL_W-1:0] y
);
  localparam logic signed [VOL_W:0] HI = {2'b00, {(VOL_W-1){1'b1}}};
  localparam logic signed [VOL_W:0] LO = {2'b11, {(VOL_W-1){1'b0}}};

  logic signed [VOL_W:0] diff;

  always_comb begin
    diff = {a[VOL_W-1], a} - {b[VOL_W-1], b};
    if (diff > HI)      y = HI[VOL_W-1:0];
    else if (diff < LO) y = LO[VOL_W-1:0];
    else                y = diff[VOL_W-1:0];
  end
endmodule

// File: rtl/gain_splitter.sv
module gain_splitter #(
  parameter int NUM_CH     = 8,
  parameter int VOL_W      = 8,
  parameter int LSB_PER_DB = 2,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      sup_en,
  input  logic                      sub_excl,
  input  logic [1:0]                range_sel,
  input  logic [NUM_CH*VOL_W-1:0]   vol_in,
  output logic                      busy,
  output logic                      done,
  output logic [VOL_W-1:0]          sup_gain,
  output logic [NUM_CH*VOL_W-1:0]   dig_gain
);
  import gs_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CH - 1);

  logic                    load, scan_en, clamp_en, wr_en;
  logic [IDX_W-1:0]        idx;
  logic signed [VOL_W-1:0] vol_mem [NUM_CH];
  logic signed [VOL_W-1:0] dig_q   [NUM_CH];
  logic signed [VOL_W-1:0] sup_q;
  logic signed [VOL_W-1:0] max_q;
  logic signed [VOL_W-1:0] floor_v;
  logic signed [VOL_W-1:0] cur_vol, sub_b, dig_next;
  logic                    en_q, excl_q, seen;
  logic [1:0]              rng_q;
  logic                    cur_incl;

  gs_ctrl #(.NUM_CH(NUM_CH)) i_ctrl (
    .clk(clk), .rst(rst), .start(start), .load(load), .scan_en(scan_en),
    .clamp_en(clamp_en), .wr_en(wr_en), .idx(idx), .busy(busy), .done(done)
  );

  // input snapshot, written once per accepted start
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_snap
      always_ff @(posedge clk) begin
        if (rst)       vol_mem[c] <= '0;
        else if (load) vol_mem[c] <= vol_in[c*VOL_W +: VOL_W];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      excl_q <= 1'b0;
      rng_q  <= 2'd0;
    end else if (load) begin
      en_q   <= sup_en;
      excl_q <= sub_excl;
      rng_q  <= range_sel;
    end
  end

  assign cur_vol  = vol_mem[idx];
  assign cur_incl = !(excl_q && (idx == LAST));

  gs_max_scan #(.VOL_W(VOL_W)) i_max (
    .clk(clk), .rst(rst), .clear(load), .en(scan_en), .valid(cur_incl),
    .din(cur_vol), .max_q(max_q), .seen(seen)
  );

  assign floor_v = VOL_W'(-(range_db(rng_q) * LSB_PER_DB));

  always_ff @(posedge clk) begin
    if (rst) begin
      sup_q <= '0;
    end else if (clamp_en) begin
      if (!en_q || !seen)      sup_q <= '0;
      else if (max_q > 0)      sup_q <= '0;
      else if (max_q < floor_v) sup_q <= floor_v;
      else                     sup_q <= max_q;
    end
  end

  assign sub_b = cur_incl ? sup_q : '0;

  gs_sub_sat #(.VOL_W(VOL_W)) i_sub (.a(cur_vol), .b(sub_b), .y(dig_next));

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_dig
      always_ff @(posedge clk) begin
        if (rst) dig_q[c] <= '0;
        else if (wr_en && (idx == IDX_W'(c))) dig_q[c] <= dig_next;
      end
      assign dig_gain[c*VOL_W +: VOL_W] = dig_q[c];
    end
  endgenerate

  assign sup_gain = sup_q;
endmodule

// File: rtl/gs_checker.sv
module gs_checker #(
  parameter int NUM_CH     = 8,
  parameter int VOL_W      = 8,
  parameter int LSB_PER_DB = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic                    en_q,
  input logic signed [VOL_W-1:0] sup_gain,
  input logic [NUM_CH*VOL_W-1:0] dig_gain
);
  localparam int MAX_FLOOR = 24 * LSB_PER_DB;

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R2
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));

  // R6
  sup_window_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (sup_gain <= 0 && sup_gain >= -MAX_FLOOR));

  // R8
  sup_off_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !en_q) |-> (sup_gain == 0));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> ($stable(sup_gain) && $stable(dig_gain)));
endmodule

bind gain_splitter gs_checker #(
  .NUM_CH(NUM_CH), .VOL_W(VOL_W), .LSB_PER_DB(LSB_PER_DB)
) i_gs_checker (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .en_q(en_q), .sup_gain(sup_gain), .dig_gain(dig_gain)
);

// File: tb/test_gain_splitter.sv
module test_gain_splitter;
  localparam int NCH = 8;
  localparam int VW  = 8;
  localparam int LAT = 2 * NCH + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, sup_en = 1'b0, sub_excl = 1'b0;
  logic [1:0] range_sel = 2'd0;
  logic [NCH*VW-1:0] vol_in = '0;
  logic busy, done;
  logic [VW-1:0] sup_gain;
  logic [NCH*VW-1:0] dig_gain;

  int checks = 0;
  int errors = 0;
  logic [31:0] lfsr = 32'hACE1_2345;

  always #2.5 clk = ~clk;

  gain_splitter #(.NUM_CH(NCH), .VOL_W(VW)) i_gain_splitter (
    .clk(clk), .rst(rst), .start(start), .sup_en(sup_en), .sub_excl(sub_excl),
    .range_sel(range_sel), .vol_in(vol_in), .busy(busy), .done(done),
    .sup_gain(sup_gain), .dig_gain(dig_gain)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int dig_of(input int c);
    return int'($signed(dig_gain[c*VW +: VW]));
  endfunction

  task automatic model(input int v[NCH], input bit en, input bit ex, input int rng,
                       output int sup, output int dg[NCH]);
    int fl, mx, d;
    bit any;
    fl = (rng == 1) ? -36 : (rng == 2) ? -48 : -24;
    mx = 0; any = 0;
    for (int c = 0; c < NCH; c++)
      if (!(ex && c == NCH-1) && (!any || v[c] > mx)) begin mx = v[c]; any = 1; end
    if (!en || !any) sup = 0;
    else if (mx > 0) sup = 0;
    else if (mx < fl) sup = fl;
    else sup = mx;
    for (int c = 0; c < NCH; c++) begin
      d = v[c] - ((ex && c == NCH-1) ? 0 : sup);
      if (d > 127) d = 127;
      if (d < -128) d = -128;
      dg[c] = d;
    end
  endtask

  task automatic drive(input int v[NCH], input bit en, input bit ex, input int rng);
    for (int c = 0; c < NCH; c++) vol_in[c*VW +: VW] = VW'(v[c]);
    sup_en = en; sub_excl = ex; range_sel = 2'(rng);
  endtask

  // called at a negedge; returns at the negedge where done is seen
  task automatic wait_done(output int lat);
    lat = 0;
    start = 1'b1;
    @(negedge clk); lat = 1; start = 1'b0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
  endtask

  task automatic verify(input string tag, input int v[NCH], input bit en,
                        input bit ex, input int rng, input int lat);
    int es; int ed[NCH];
    model(v, en, ex, rng, es, ed);
    check({tag, " R3 latency"}, lat, LAT);
    check({tag, " sup_gain"}, int'($signed(sup_gain)), es);
    for (int c = 0; c < NCH; c++) check({tag, " R7 dig"}, dig_of(c), ed[c]);
  endtask

  task automatic next_rand(output int r);
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    r = int'(lfsr[15:0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R3 actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v[NCH]; int w[NCH]; int lat; int r; int base;
    int es; int ed[NCH];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 sup", int'(sup_gain), 0);
    check("R1 dig", int'(dig_gain != '0), 0);

    // R6 example: range 18 dB, loudest below floor
    v = '{-56, -56, -44, -100, -120, -90, -80, -70};
    drive(v, 1, 0, 1); wait_done(lat); verify("R6 below floor", v, 1, 0, 1, lat);
    check("R6 sup", int'($signed(sup_gain)), -36);
    check("R7 ch0", dig_of(0), -20);
    // R5 within range
    v = '{-28, -56, -44, -60, -60, -60, -60, -60};
    drive(v, 1, 0, 1); @(negedge clk); wait_done(lat); verify("R5 within", v, 1, 0, 1, lat);
    check("R5 sup", int'($signed(sup_gain)), -28);
    // R4 above zero
    v = '{-28, 8, -44, -60, -60, -60, -60, -60};
    drive(v, 1, 0, 2); @(negedge clk); wait_done(lat); verify("R4 above", v, 1, 0, 2, lat);
    check("R4 sup", int'($signed(sup_gain)), 0);
    // R6 reserved code acts as 12 dB
    v = '{-100, -100, -100, -100, -100, -100, -100, -90};
    drive(v, 1, 0, 3); @(negedge clk); wait_done(lat); verify("R6 reserved", v, 1, 0, 3, lat);
    check("R6 reserved sup", int'($signed(sup_gain)), -24);
    // R8 disabled
    v = '{-20, -30, 10, -60, -5, -60, -60, -60};
    drive(v, 0, 0, 2); @(negedge clk); wait_done(lat); verify("R8 off", v, 0, 0, 2, lat);
    check("R8 ch2", dig_of(2), 10);
    // R9 loud subwoofer excluded
    v = '{-40, -30, -50, -60, -45, -60, -60, 20};
    drive(v, 1, 1, 2); @(negedge clk); wait_done(lat); verify("R9 excl", v, 1, 1, 2, lat);
    check("R9 sup", int'($signed(sup_gain)), -30);
    check("R9 sub dig", dig_of(NCH-1), 20);
    // R9 same inputs with sub included
    drive(v, 1, 0, 2); @(negedge clk); wait_done(lat); verify("R9 incl", v, 1, 0, 2, lat);
    check("R9 incl sup", int'($signed(sup_gain)), 0);

    // R2 start while busy is ignored
    v = '{-10, -20, -30, -40, -50, -60, -70, -80};
    w = '{5, 5, 5, 5, 5, 5, 5, 5};
    drive(v, 1, 0, 0); @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    drive(w, 0, 1, 2); start = 1'b1; @(negedge clk); start = 1'b0;
    lat = 4;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    verify("R2 busy start", v, 1, 0, 0, lat);
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      if (done) check("R2 extra done", 1, 0);
    end
    // R10 hold after done
    check("R10 hold sup", int'($signed(sup_gain)), -10);
    check("R10 hold dig", dig_of(7), -70);

    // R10 start in the done cycle
    v = '{-30, -34, -50, -60, -60, -60, -60, -60};
    drive(v, 1, 0, 2); @(negedge clk); wait_done(lat);
    verify("R10 first", v, 1, 0, 2, lat);
    w = '{-90, -100, -95, -110, -120, -99, -91, -60};
    drive(w, 1, 1, 0); wait_done(lat);
    verify("R10 back-to-back", w, 1, 1, 0, lat);

    // sweep over range codes, enables and clustered random volumes
    for (int n = 0; n < 400; n++) begin
      next_rand(r); base = (r % 140) - 120;
      for (int c = 0; c < NCH; c++) begin
        next_rand(r);
        v[c] = base - (r % 40) + ((c == NCH-1 && n % 5 == 0) ? 30 : 0);
        if (v[c] > 127) v[c] = 127;
        if (v[c] < -128) v[c] = -128;
      end
      drive(v, (n % 7) != 3, (n % 3) == 1, n % 4);
      @(negedge clk); wait_done(lat);
      verify("R4 R5 R6 R7 sweep", v, (n % 7) != 3, (n % 3) == 1, n % 4, lat);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule